// File: doc/BRIEF.md
# Real-Time Clock with Periodic Bus Publication

This block keeps wall-clock time for a chip: a seconds count and a millisecond count. Both advance from the rising edges of a slow reference clock in the 32 kHz class. The reference is sampled into the bus clock domain by a short synchronizer. The running counters are not read directly. Once in every eight reference periods the block opens a publication window, during which a busy flag is raised and the running values are copied into bus-visible registers. Outside that window the bus-visible values stay frozen, so software always sees a consistent pair.

Software uses a simple select/write/address register port. Reading the millisecond register also captures the bus-visible seconds into a shadow register, so the next shadow read pairs with that millisecond value. Writes are accepted only outside the publication window. A seconds alarm compares against the counter as it counts up. An interrupt status register with write-one-to-clear bits, gated by a mask register, drives a level-high interrupt line.

Top module: `rtc_shadow_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The millisecond count advances so that exactly MS_PER_SEC counts elapse per TICKS_PER_SEC reference rising edges (defaults 1000 and 32768). It wraps from MS_PER_SEC-1 to 0, and that wrap adds one to the seconds count, modulo 2^32.
- R3: Offset 0x004 reads 1 in bit 0 while the low DIV_W bits (default 3) of a free-running reference-edge counter are all ones. This is one reference period out of every eight. Seconds (0x008) and milliseconds (0x010) refresh from the running counters only during that window and hold otherwise.
- R4: A read of 0x010 copies the bus-visible seconds into the shadow register at 0x00C. No other event changes the shadow register.
- R5: Any write made while bit 0 of 0x004 is 1 has no effect.
- R6: An accepted write to 0x008 loads both the running and the bus-visible seconds. It also sets both millisecond values and the fractional phase to zero.
- R7: Status bit 0 sets when the seconds count, by counting up, becomes equal to a nonzero alarm value held at 0x014 (readable back). An alarm value of 0 never fires. Loading the seconds through a write does not fire the alarm.
- R8: Status at 0x02C has five bits: bit 0 seconds alarm, bit 1 second alarm, bit 2 millisecond alarm, bit 3 seconds countdown, bit 4 millisecond countdown. Writing 1 to a bit clears it and writing 0 leaves it unchanged. Only bit 0 is ever set by hardware.
- R9: Mask at 0x028 stores five bits in the same layout, and higher write bits are dropped. `irq` is high exactly when status AND mask is nonzero.
- R10: Read data appears on `bus_rdata` in the cycle after the request. Unused offsets, including 0x018 and 0x01C, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Slow reference clock, sampled by the synchronizer |
| bus_sel | input | 1 | Register access request, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| irq | output | 1 | Level-high interrupt |

## Verification
The assertions assume that the reference input changes slowly relative to the bus clock, so each reference edge produces a single tick. They also assume that software honours the busy rule, so a seconds load never coincides with a tick. The bench keeps this true in two ways. It drives every reference period as four bus cycles high and four low. It issues register writes only between ticks, and only outside the publication window, except for writes that deliberately test the busy rule.

// File: rtl/rtc_shadow_pkg.sv
`timescale 1ns/1ps
package rtc_shadow_pkg;
   // Byte offsets of the register port; software decodes these.
   localparam logic [7:0] OFF_BUSY   = 8'h04;
   localparam logic [7:0] OFF_SEC    = 8'h08;
   localparam logic [7:0] OFF_SHADOW = 8'h0C;
   localparam logic [7:0] OFF_MS     = 8'h10;
   localparam logic [7:0] OFF_ALM0   = 8'h14;
   localparam logic [7:0] OFF_MASK   = 8'h28;
   localparam logic [7:0] OFF_STAT   = 8'h2C;
   // Interrupt vector layout shared by status and mask.
   localparam int IRQ_BITS = 5;
   localparam int IRQ_ALM0 = 0;
endpackage

// File: rtl/rtc_tick_sync.sv
`timescale 1ns/1ps
module rtc_tick_sync #(
   parameter bit USE_SYNC = 1'b1,
   parameter int STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic tick
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtc_tick_sync: STAGES must be at least 2");
   end

   if (USE_SYNC) begin : g_sync
      logic [STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-1:0], ref_in};
      end
      assign tick = sh[STAGES-1] & ~sh[STAGES];
   end else begin : g_direct
      // Reference already arrives as a one-cycle strobe in the bus domain.
      assign tick = ref_in;
   end
endmodule

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
module rtc_timebase #(
   parameter int SEC_W         = 32,
   parameter int TICKS_PER_SEC = 32768,
   parameter int MS_PER_SEC    = 1000,
   parameter int DIV_W         = 3,
   localparam int MS_W  = $clog2(MS_PER_SEC),
   localparam int ACC_W = $clog2(TICKS_PER_SEC) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [SEC_W-1:0] load_val,
   output logic [SEC_W-1:0] run_sec,
   output logic [MS_W-1:0]  run_ms,
   output logic             busy,
   output logic             sec_step
);
   localparam logic [ACC_W-1:0] ACC_LIM  = ACC_W'(TICKS_PER_SEC);
   localparam logic [ACC_W-1:0] ACC_STEP = ACC_W'(MS_PER_SEC);
   localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(MS_PER_SEC - 1);

   if (MS_PER_SEC < 2 || MS_PER_SEC > TICKS_PER_SEC) begin : g_bad_rate
      $error("rtc_timebase: need 2 <= MS_PER_SEC <= TICKS_PER_SEC");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("rtc_timebase: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] div;
   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_sum;
   logic             ms_adv;

   assign acc_sum  = acc + ACC_STEP;
   assign ms_adv   = acc_sum >= ACC_LIM;
   assign busy     = &div;
   assign sec_step = tick & ~load & ms_adv & (run_ms == MS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div     <= '0;
         acc     <= '0;
         run_ms  <= '0;
         run_sec <= '0;
      end else begin
         if (tick) div <= div + DIV_W'(1);
         if (load) begin
            run_sec <= load_val;
            run_ms  <= '0;
            acc     <= '0;
         end else if (tick) begin
            if (ms_adv) begin
               acc <= acc_sum - ACC_LIM;
               if (run_ms == MS_LAST) begin
                  run_ms  <= '0;
                  run_sec <= run_sec + SEC_W'(1);
               end else begin
                  run_ms <= run_ms + MS_W'(1);
               end
            end else begin
               acc <= acc_sum;
            end
         end
      end
   end
endmodule

// File: rtl/rtc_regs.sv
`timescale 1ns/1ps
module rtc_regs
   import rtc_shadow_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int SEC_W  = 32,
   parameter int MS_W   = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                wr,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                busy,
   input  logic [SEC_W-1:0]    run_sec,
   input  logic [MS_W-1:0]     run_ms,
   input  logic                sec_step,
   output logic                load,
   output logic [DATA_W-1:0]   rdata,
   output logic [IRQ_BITS-1:0] status,
   output logic [IRQ_BITS-1:0] mask
);
   localparam logic [ADDR_W-1:0] A_BUSY   = ADDR_W'(OFF_BUSY);
   localparam logic [ADDR_W-1:0] A_SEC    = ADDR_W'(OFF_SEC);
   localparam logic [ADDR_W-1:0] A_SHADOW = ADDR_W'(OFF_SHADOW);
   localparam logic [ADDR_W-1:0] A_MS     = ADDR_W'(OFF_MS);
   localparam logic [ADDR_W-1:0] A_ALM0   = ADDR_W'(OFF_ALM0);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);

   logic [SEC_W-1:0]    bus_sec, shadow, alarm0;
   logic [MS_W-1:0]     bus_ms;
   logic [IRQ_BITS-1:0] clr_vec, set_vec, status_nxt;
   logic [DATA_W-1:0]   rd_mux;
   logic                wr_ok, rd, alarm_hit;

   assign wr_ok     = sel & wr & ~busy;
   assign rd        = sel & ~wr;
   assign load      = wr_ok & (addr == A_SEC);
   assign alarm_hit = sec_step & (alarm0 != '0) & ((run_sec + SEC_W'(1)) == alarm0);

   always_comb begin
      clr_vec = (wr_ok && addr == A_STAT) ? wdata[IRQ_BITS-1:0] : '0;
      set_vec = '0;
      set_vec[IRQ_ALM0] = alarm_hit;
      status_nxt = (status & ~clr_vec) | set_vec;
   end

   always_comb begin
      case (addr)
         A_BUSY:   rd_mux = DATA_W'(busy);
         A_SEC:    rd_mux = DATA_W'(bus_sec);
         A_SHADOW: rd_mux = DATA_W'(shadow);
         A_MS:     rd_mux = DATA_W'(bus_ms);
         A_ALM0:   rd_mux = DATA_W'(alarm0);
         A_MASK:   rd_mux = DATA_W'(mask);
         A_STAT:   rd_mux = DATA_W'(status);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_sec <= '0;
         bus_ms  <= '0;
         shadow  <= '0;
         alarm0  <= '0;
         mask    <= '0;
         status  <= '0;
         rdata   <= '0;
      end else begin
         if (busy) begin
            bus_sec <= run_sec;
            bus_ms  <= run_ms;
         end else if (load) begin
            bus_sec <= wdata[SEC_W-1:0];
            bus_ms  <= '0;
         end
         if (rd && addr == A_MS)                 shadow <= bus_sec;
         if (wr_ok && addr == A_ALM0)            alarm0 <= wdata[SEC_W-1:0];
         if (wr_ok && addr == A_MASK)            mask   <= wdata[IRQ_BITS-1:0];
         status <= status_nxt;
         rdata  <= rd ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/rtc_shadow_top.sv
`timescale 1ns/1ps
module rtc_shadow_top
   import rtc_shadow_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int SEC_W         = 32,
   parameter int TICKS_PER_SEC = 32768,
   parameter int MS_PER_SEC    = 1000,
   parameter int DIV_W         = 3,
   parameter bit USE_SYNC      = 1'b1,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int MS_W = $clog2(MS_PER_SEC);

   if (SEC_W > DATA_W) begin : g_bad_sec
      $error("rtc_shadow_top: SEC_W must not exceed DATA_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("rtc_shadow_top: ADDR_W too small for the register map");
   end

   logic                tick, load, busy, sec_step;
   logic [SEC_W-1:0]    run_sec;
   logic [MS_W-1:0]     run_ms;
   logic [IRQ_BITS-1:0] status, mask;

   rtc_tick_sync #(.USE_SYNC(USE_SYNC), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .tick(tick)
   );

   rtc_timebase #(
      .SEC_W(SEC_W), .TICKS_PER_SEC(TICKS_PER_SEC),
      .MS_PER_SEC(MS_PER_SEC), .DIV_W(DIV_W)
   ) i_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
      .load_val(bus_wdata[SEC_W-1:0]), .run_sec(run_sec), .run_ms(run_ms),
      .busy(busy), .sec_step(sec_step)
   );

   rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .busy(busy), .run_sec(run_sec), .run_ms(run_ms),
      .sec_step(sec_step), .load(load), .rdata(bus_rdata),
      .status(status), .mask(mask)
   );

   assign irq = |(status & mask);
endmodule

// File: rtl/rtc_shadow_chk.sv
`timescale 1ns/1ps
module rtc_shadow_chk
   import rtc_shadow_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int MS_PER_SEC = 1000,
   parameter int MS_W       = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                irq,
   input logic                tick,
   input logic                busy,
   input logic                sec_step,
   input logic [MS_W-1:0]     run_ms,
   input logic [IRQ_BITS-1:0] status,
   input logic [IRQ_BITS-1:0] mask
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [MS_W-1:0]   MS_LIM = MS_W'(MS_PER_SEC - 1);

   a_r2_ms_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run_ms <= MS_LIM);
   a_r2_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      sec_step |-> tick);
   a_r3_busy_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(busy));
   a_r3_busy_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tick));
   a_r5_busy_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_sel && bus_wr) |=> $stable(mask));
   a_r7_alarm_from_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[IRQ_ALM0]) |-> $past(sec_step));
   a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !busy && bus_addr == A_STAT && bus_wdata[IRQ_ALM0] && !sec_step)
      |=> !status[IRQ_ALM0]);
   a_r8_hw_sets_bit0_only: assert property (@(posedge clk) disable iff (!rst_n)
      status[IRQ_BITS-1:1] == '0);
   a_r9_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0 && mask != '0));
endmodule

bind rtc_shadow_top rtc_shadow_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .tick(tick),
   .busy(busy), .sec_step(sec_step), .run_ms(run_ms),
   .status(status), .mask(mask)
);

// File: tb/test_rtc_shadow_top.sv
`timescale 1ns/1ps
module test_rtc_shadow_top;
   localparam int TPS = 32;
   localparam int MPS = 8;
   localparam int TICKS_PER_MS = TPS / MPS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_in = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   // bench time model
   int unsigned tcount = 0;
   int unsigned load_tc = 0;
   logic [31:0] base = '0;
   logic [31:0] bsec = '0;
   logic [31:0] bms = '0;

   always #2.5 clk = ~clk;

   rtc_shadow_top #(.TICKS_PER_SEC(TPS), .MS_PER_SEC(MPS)) i_rtc_shadow_top (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard one cycle after each read request
   always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) chk("R10 unexpected read", 32'h1, 32'h0);
         else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   function automatic logic [31:0] m_sec();
      return base + 32'((tcount - load_tc) / TPS);
   endfunction
   function automatic logic [31:0] m_ms();
      return 32'(((tcount - load_tc) / TICKS_PER_MS) % MPS);
   endfunction

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         ref_in = 1'b1;
         repeat (4) @(negedge clk);
         ref_in = 1'b0;
         repeat (4) @(negedge clk);
         tcount++;
         if (tcount % 8 == 7) begin
            bsec = m_sec();
            bms  = m_ms();
         end
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr_sec(input logic [31:0] d);
      wr(8'h08, d);
      base = d; load_tc = tcount; bsec = d; bms = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk("R1 irq after reset", 32'(irq), 32'h0);
      rd(8'h04, 32'h0, "R1 busy after reset");
      rd(8'h08, 32'h0, "R1 seconds after reset");
      rd(8'h0C, 32'h0, "R1 shadow after reset");
      rd(8'h14, 32'h0, "R1 alarm after reset");
      rd(8'h28, 32'h0, "R1 mask after reset");
      rd(8'h2C, 32'h0, "R1 status after reset");

      // R3 window opens on the eighth phase; copy taken there
      tick_n(7);
      rd(8'h04, 32'h1, "R3 busy in window");
      rd(8'h10, m_ms(), "R3 ms copied in window");
      wr(8'h08, 32'd100);
      rd(8'h08, 32'h0, "R5 seconds write while busy ignored");
      wr(8'h28, 32'h1F);
      rd(8'h28, 32'h0, "R5 mask write while busy ignored");

      // R6 seconds load outside the window
      tick_n(1);
      rd(8'h04, 32'h0, "R3 busy clear after window");
      wr_sec(32'd100);
      rd(8'h08, 32'd100, "R6 seconds loaded");
      rd(8'h10, 32'h0, "R6 ms zeroed by load");

      // R2 / R4 millisecond count and shadow pairing
      tick_n(15);
      rd(8'h10, 32'd3, "R2 ms after 15 ticks");
      rd(8'h0C, 32'd100, "R4 shadow captured by ms read");
      tick_n(24);
      rd(8'h08, 32'd101, "R2 seconds after ms wrap");
      rd(8'h0C, 32'd100, "R4 shadow holds without ms read");
      tick_n(1);
      rd(8'h10, bms, "R3 ms stale outside window");
      chk("R3 model stale value", bms, 32'd1);
      rd(8'h0C, 32'd101, "R4 shadow follows new ms read");

      // R10 unused offsets
      rd(8'h18, 32'h0, "R10 offset 0x18 reads zero");
      rd(8'h1C, 32'h0, "R10 offset 0x1C reads zero");

      // R7 alarm fires when counting reaches 103
      wr(8'h14, 32'd103);
      wr(8'h28, 32'h1);
      rd(8'h14, 32'd103, "R7 alarm readback");
      tick_n(55);
      rd(8'h2C, 32'h0, "R7 status before match");
      chk("R9 irq before match", 32'(irq), 32'h0);
      tick_n(1);
      rd(8'h2C, 32'h1, "R7 status at match");
      chk("R9 irq at match", 32'(irq), 32'h1);

      // R9 mask gating, R8 write-one-to-clear
      wr(8'h28, 32'h0);
      chk("R9 irq masked", 32'(irq), 32'h0);
      rd(8'h2C, 32'h1, "R9 status kept while masked");
      wr(8'h28, 32'h1);
      chk("R9 irq unmasked", 32'(irq), 32'h1);
      wr(8'h2C, 32'h1E);
      rd(8'h2C, 32'h1, "R8 zero bits leave status");
      wr(8'h2C, 32'h1);
      rd(8'h2C, 32'h0, "R8 one clears status");
      chk("R9 irq after clear", 32'(irq), 32'h0);

      // R5 again in the next window; R9 mask width
      tick_n(7);
      rd(8'h04, 32'h1, "R3 busy in later window");
      wr(8'h28, 32'h1E);
      rd(8'h28, 32'h1, "R5 mask unchanged in window");
      tick_n(1);
      wr(8'h28, 32'hFFFF_FFFF);
      rd(8'h28, 32'h1F, "R9 mask stores five bits");
      wr(8'h28, 32'h1);

      // R2 wrap of seconds, R7 zero alarm never fires
      wr(8'h14, 32'h0);
      wr_sec(32'hFFFF_FFFF);
      tick_n(39);
      rd(8'h08, 32'h0, "R2 seconds wrap to zero");
      rd(8'h2C, 32'h0, "R7 zero alarm silent");
      tick_n(1);

      // R7 a load equal to the alarm does not fire
      wr(8'h14, 32'd5);
      wr_sec(32'd5);
      rd(8'h08, 32'd5, "R6 second load readback");
      rd(8'h2C, 32'h0, "R7 load does not fire alarm");
      chk("R7 irq after load", 32'(irq), 32'h0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) chk("R10 reads left unanswered", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule